// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the settings that steer a frequency synthesizer: a 9-bit feedback divider value, a 2-bit output divider code and a 2-bit test selector. Two paths can load the settings. The parallel path takes them from static input pins under an active-low load strobe. The serial path moves them through a shift register, one bit per rising edge of a serial clock, and commits the shift register under a separate load strobe. The block also drives a test output through a four-way selector. The selector picks among a constant low, the serial data pin, the feedback divider output and the synthesized clock.

All control pins are sampled by the system clock `clk`. Edges on the serial clock and on both strobes are found by comparing each pin with its value from the previous cycle, so every action takes effect one `clk` edge after the pin changes. A flag reports when the held feedback value lies outside the range in which the loop is expected to lock with the nominal reference.

Top module: `synthCfgLoader`

## Requirements
- R1: An active-low asynchronous reset (`rstN` low) sets the feedback value to 25, the output code to 0, the test selector to 0 and the shift register to zero.
- R2: While `parLoadN` is low, every `clk` edge copies `parM` and `parN` into `mDiv` and `nDiv`.
- R3: Once `parLoadN` is high, `mDiv` and `nDiv` keep their last value and do not follow later changes on `parM` and `parN` until a serial commit occurs or `parLoadN` goes low again.
- R4: The shift register moves one place on each rising edge of `serClk`, and only while `parLoadN` is high. Each move shifts the contents toward the MSB and takes `serData` into bit 0. Rising `serClk` edges while `parLoadN` is low leave the shift register untouched.
- R5: A rising edge of `serLoad` while `parLoadN` is high commits the 14-bit shift register. Bits 13:12 go to the test selector, bit 11 is the null slot, bits 10:9 go to `nDiv` and bits 8:0 go to `mDiv`. A frame is therefore sent first-bit-first in this order: T1, T0, null, N1, N0, then M8 down to M0.
- R6: While `serLoad` stays high, each rising `serClk` edge shifts the register and commits the shifted result in the same cycle.
- R7: After `serLoad` falls, further serial shifts leave `mDiv`, `nDiv` and the test selector unchanged.
- R8: The value in the null slot has no effect on any held setting or on `testOut`.
- R9: When `parLoadN` is high, `testOut` follows the test selector {T1,T0}. The code 00 gives low, 01 gives `serData`, 10 gives `fbDivIn` and 11 gives `synthClkIn`.
- R10: `testOut` is low whenever `parLoadN` is low, whatever the selector code.
- R11: `lockRisk` is high exactly when `mDiv` is below 25 or above 31.
- R12: When a rising `serClk` edge and a rising `serLoad` edge are seen in the same `clk` cycle, the committed value includes the bit shifted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control pin |
| rstN | input | 1 | Asynchronous reset, active low |
| parLoadN | input | 1 | Parallel load strobe, active low; high selects serial mode |
| parM | input | 9 | Parallel feedback divider value |
| parN | input | 2 | Parallel output divider code |
| serClk | input | 1 | Serial shift clock, sampled by `clk` |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Serial commit strobe |
| fbDivIn | input | 1 | Feedback divider output, routed to the test output |
| synthClkIn | input | 1 | Synthesized clock, routed to the test output |
| mDiv | output | 9 | Held feedback divider value |
| nDiv | output | 2 | Held output divider code |
| testOut | output | 1 | Selected test signal |
| lockRisk | output | 1 | High when `mDiv` is outside 25..31 |

## Verification
Shifting and committing can fall in the same cycle. The bench provokes this in two ways. It raises `serClk` and `serLoad` on the same sampling edge after only 13 bits have been shifted. It also keeps `serLoad` high while single bits are clocked in. In both cases the held settings must equal the fields of the shift register after the shift, never before it. The bench tracks its own model of the shift register to judge this. A second pairing checks that serial clock edges seen during a parallel load neither shift nor commit.

// File: rtl/cfgLoadPkg.sv
package cfgLoadPkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 2;
  localparam int NULL_W = 1;
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
  localparam int N_LSB = M_W;
  localparam int T_LSB = M_W + N_W + NULL_W;

  typedef struct packed {
    logic loadPar;
    logic shiftEn;
    logic loadSer;
  } strobe_t;
endpackage

// File: rtl/cfgLoadCtrl.sv
module cfgLoadCtrl
  import cfgLoadPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    parLoadN,
  input  logic    serClk,
  input  logic    serLoad,
  output strobe_t strobe
);
  logic serClkQ;
  logic serLoadQ;
  logic serClkRise;
  logic serLoadRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ  <= 1'b0;
      serLoadQ <= 1'b0;
    end else begin
      serClkQ  <= serClk;
      serLoadQ <= serLoad;
    end
  end

  assign serClkRise  = serClk & ~serClkQ;
  assign serLoadRise = serLoad & ~serLoadQ;

  always_comb begin
    strobe.loadPar = ~parLoadN;
    strobe.shiftEn = parLoadN & serClkRise;
    strobe.loadSer = parLoadN & (serLoadRise | (serLoad & serClkRise));
  end

  // parallel and serial actions never overlap (R4)
  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPar |-> !(strobe.shiftEn || strobe.loadSer));

  // a held serial strobe with a serial clock rise always commits (R6)
  p_held_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (parLoadN && serLoad && serClk && !serClkQ) |-> strobe.loadSer);
endmodule

// File: rtl/cfgLoadDatapath.sv
module cfgLoadDatapath
  import cfgLoadPkg::*;
#(
  parameter int M_RESET  = 25,
  parameter int LOCK_MIN = 25,
  parameter int LOCK_MAX = 31
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobe,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  input  logic           serData,
  output logic [M_W-1:0] mDiv,
  output logic [N_W-1:0] nDiv,
  output logic [T_W-1:0] tSel,
  output logic           lockRisk
);
  localparam logic [M_W-1:0] M_RST_V = M_W'(M_RESET);
  localparam logic [M_W-1:0] LOCK_LO = M_W'(LOCK_MIN);
  localparam logic [M_W-1:0] LOCK_HI = M_W'(LOCK_MAX);

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] shiftNext;
  logic [M_W-1:0]     mReg;
  logic [N_W-1:0]     nReg;
  logic [T_W-1:0]     tReg;

  assign shiftNext = strobe.shiftEn ? {shiftReg[FRAME_W-2:0], serData} : shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mReg     <= M_RST_V;
      nReg     <= '0;
      tReg     <= '0;
    end else begin
      shiftReg <= shiftNext;
      if (strobe.loadPar) begin
        mReg <= parM;
        nReg <= parN;
      end else if (strobe.loadSer) begin
        mReg <= shiftNext[M_W-1:0];
        nReg <= shiftNext[N_LSB +: N_W];
        tReg <= shiftNext[T_LSB +: T_W];
      end
    end
  end

  assign mDiv     = mReg;
  assign nDiv     = nReg;
  assign tSel     = tReg;
  assign lockRisk = (mReg < LOCK_LO) || (mReg > LOCK_HI);

  // parallel transparency (R2)
  p_par_track_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPar |=> (mReg == $past(parM)) && (nReg == $past(parN)));

  // no load strobe means settings hold (R3, R7)
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadPar && !strobe.loadSer) |=> $stable(mReg) && $stable(nReg) && $stable(tReg));

  // a shift takes the serial bit into bit 0 (R4)
  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[0] == $past(serData));

  // no shift strobe keeps the shift register (R4)
  p_shift_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg));
endmodule

// File: rtl/synthCfgLoader.sv
module synthCfgLoader
  import cfgLoadPkg::*;
#(
  parameter int M_RESET  = 25,
  parameter int LOCK_MIN = 25,
  parameter int LOCK_MAX = 31
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           parLoadN,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           fbDivIn,
  input  logic           synthClkIn,
  output logic [M_W-1:0] mDiv,
  output logic [N_W-1:0] nDiv,
  output logic           testOut,
  output logic           lockRisk
);
  strobe_t        strobe;
  logic [T_W-1:0] tSel;

  cfgLoadCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .parLoadN (parLoadN),
    .serClk   (serClk),
    .serLoad  (serLoad),
    .strobe   (strobe)
  );

  cfgLoadDatapath #(
    .M_RESET  (M_RESET),
    .LOCK_MIN (LOCK_MIN),
    .LOCK_MAX (LOCK_MAX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .parM     (parM),
    .parN     (parN),
    .serData  (serData),
    .mDiv     (mDiv),
    .nDiv     (nDiv),
    .tSel     (tSel),
    .lockRisk (lockRisk)
  );

  always_comb begin
    if (!parLoadN) begin
      testOut = 1'b0;
    end else begin
      unique case (tSel)
        2'b00:   testOut = 1'b0;
        2'b01:   testOut = serData;
        2'b10:   testOut = fbDivIn;
        default: testOut = synthClkIn;
      endcase
    end
  end

  // parallel mode forces the test output low (R10)
  p_test_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !parLoadN |-> !testOut);

  // out-of-range flag agrees with the held value (R11)
  p_lock_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    lockRisk == ((mDiv < 9'd25) || (mDiv > 9'd31)));
endmodule

// File: tb/synthCfgLoader_bench.sv
module synthCfgLoader_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       parLoadN = 1'b1;
  logic [8:0] parM = '0;
  logic [1:0] parN = '0;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       serLoad = 1'b0;
  logic       fbDivIn = 1'b0;
  logic       synthClkIn = 1'b0;
  logic [8:0] mDiv;
  logic [1:0] nDiv;
  logic       testOut;
  logic       lockRisk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [13:0] expSh = '0;

  always #5 clk = ~clk;

  synthCfgLoader u_synthCfgLoader (
    .clk(clk), .rstN(rstN), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .serClk(serClk), .serData(serData), .serLoad(serLoad), .fbDivIn(fbDivIn),
    .synthClkIn(synthClkIn), .mDiv(mDiv), .nDiv(nDiv), .testOut(testOut),
    .lockRisk(lockRisk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serData = b;
    serClk = 1'b1;
    @(negedge clk);
    serClk = 1'b0;
    if (parLoadN) expSh = {expSh[12:0], b};
  endtask

  task automatic sendFrame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) shiftBit(f[i]);
  endtask

  task automatic commit();
    @(negedge clk);
    serLoad = 1'b1;
    @(negedge clk);
    serLoad = 1'b0;
  endtask

  function automatic logic [13:0] mkFrame(input logic [1:0] t, input logic nb,
                                          input logic [1:0] n, input logic [8:0] m);
    return {t, nb, n, m};
  endfunction

  task automatic checkHeld(input logic [8:0] m, input logic [1:0] n, input string tag);
    check(mDiv == m, {tag, " mDiv"}, int'(mDiv), int'(m));
    check(nDiv == n, {tag, " nDiv"}, int'(nDiv), int'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] heldM;
    logic [1:0] heldN;
    logic [13:0] f;
    repeat (3) @(negedge clk);
    // R1: reset values
    checkHeld(9'd25, 2'd0, "R1");
    check(lockRisk == 1'b0, "R1 lockRisk", int'(lockRisk), 0);
    rstN = 1'b1;
    @(negedge clk);
    synthClkIn = 1'b1; fbDivIn = 1'b1; serData = 1'b1; #1;
    check(testOut == 1'b0, "R1 test code 00 after reset", int'(testOut), 0);

    // R2, R11: exhaustive parallel sweep
    parLoadN = 1'b0;
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      parM = 9'(v);
      parN = 2'(v);
      @(negedge clk);
      checkHeld(9'(v), 2'(v), "R2");
      check(lockRisk == (v < 25 || v > 31), "R11 lockRisk", int'(lockRisk), int'(v < 25 || v > 31));
    end

    // R3: latch on parLoadN rising
    @(negedge clk); parM = 9'd27; parN = 2'd2;
    @(negedge clk); parLoadN = 1'b1; parM = 9'd400; parN = 2'd1;
    repeat (3) @(negedge clk);
    checkHeld(9'd27, 2'd2, "R3");

    // R5: full serial frames, bit order
    for (int k = 0; k < 8; k++) begin
      f = mkFrame(2'(k), 1'b0, 2'(k + 1), 9'(k * 61 + 3));
      sendFrame(f);
      check(expSh == f, "R5 bench frame", int'(expSh), int'(f));
      commit();
      checkHeld(f[8:0], f[10:9], "R5");
    end

    // R8: null slot set to 1 changes nothing
    f = mkFrame(2'b00, 1'b1, 2'd3, 9'd29);
    sendFrame(f);
    commit();
    checkHeld(9'd29, 2'd3, "R8");
    @(negedge clk); synthClkIn = 1'b1; fbDivIn = 1'b1; serData = 1'b1; #1;
    check(testOut == 1'b0, "R8 testOut", int'(testOut), 0);

    // R9: all four test codes
    for (int c = 0; c < 4; c++) begin
      sendFrame(mkFrame(2'(c), 1'b0, 2'd0, 9'd30));
      commit();
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        serData = p[0]; fbDivIn = p[1]; synthClkIn = p[2]; #1;
        check(testOut == ((c == 1) ? p[0] : (c == 2) ? p[1] : (c == 3) ? p[2] : 1'b0),
              "R9 testOut", int'(testOut), int'((c == 1) ? p[0] : (c == 2) ? p[1] : (c == 3) ? p[2] : 1'b0));
      end
    end

    // R10: parallel mode forces low with code 11 held
    @(negedge clk); synthClkIn = 1'b1; #1;
    check(testOut == 1'b1, "R10 precondition", int'(testOut), 1);
    parM = 9'd26; parN = 2'd1; parLoadN = 1'b0; #1;
    check(testOut == 1'b0, "R10 testOut", int'(testOut), 0);

    // R4: serial clocks during parallel load are ignored
    heldM = expSh[8:0];
    heldN = expSh[10:9];
    for (int i = 0; i < 5; i++) shiftBit(1'(i));
    @(negedge clk); parLoadN = 1'b1;
    checkHeld(9'd26, 2'd1, "R4 parallel held");
    commit();
    checkHeld(heldM, heldN, "R4 shift untouched");

    // R6: pass-through while serLoad held high
    @(negedge clk); serLoad = 1'b1;
    for (int i = 0; i < 12; i++) begin
      shiftBit(1'((i * 5 + 1) % 3 == 0));
      checkHeld(expSh[8:0], expSh[10:9], "R6");
    end
    // R7: freeze after serLoad falls
    @(negedge clk); serLoad = 1'b0;
    heldM = expSh[8:0];
    heldN = expSh[10:9];
    for (int i = 0; i < 4; i++) shiftBit(1'(~i));
    checkHeld(heldM, heldN, "R7");

    // R12: shift and commit seen in the same cycle
    for (int k = 0; k < 4; k++) begin
      f = mkFrame(2'd0, 1'b0, 2'(3 - k), 9'(k * 97 + 11) | 9'd1);
      for (int i = 13; i >= 1; i--) shiftBit(f[i]);
      @(negedge clk);
      serData = f[0]; serClk = 1'b1; serLoad = 1'b1;
      @(negedge clk);
      serClk = 1'b0; serLoad = 1'b0;
      expSh = {expSh[12:0], f[0]};
      checkHeld(f[8:0], f[10:9], "R12");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule